// File: doc/BRIEF.md
# Sub-Blocked Direct-Mapped Cache Controller

This block is a 1 KB direct-mapped cache with 32 lines of 32 bytes. Each line is split into four 8-byte sub-blocks, and each sub-block has its own valid bit. A processor issues one request at a time: either a halfword read, or a write of one or two bytes selected by a byte mask. Two memory-side channels serve it. A fill channel returns one 8-byte beat per handshake. A write-through channel carries every processor write toward memory.

A read miss brings in the whole line. A write miss does not fetch anything. It installs the new tag, stores the written bytes, marks only the written sub-block valid and clears the other three valid bits. The per-sub-block valid bits are what let the cache keep a line whose remaining bytes were never fetched.

Top module: `sbk_cache`

## Requirements
- R1: Reset clears every valid bit in all 32 lines. After reset `cpu_req_ready` is 1, and `cpu_resp_valid`, `fill_req_valid` and `wt_valid` are 0. The first read to any address after reset misses.
- R2: Address bits 31:10 are the tag, bits 9:5 the line index, bits 4:3 the sub-block, and bits 2:1 the halfword within the 8-byte sub-block. Address bit 0 is ignored, so an odd address reads the same halfword as the even address below it.
- R3: A read hits only when the stored tag matches and the addressed sub-block is valid. A hit raises `cpu_resp_valid` two clock edges after the accepting edge and causes no fill or write-through traffic. The returned data is little-endian: bits 7:0 are the even byte.
- R4: A read miss requests sub-blocks 0, 1, 2, 3 in that order. `fill_req_addr` is {tag, index, sub-block, 3'b000}. One beat is taken on each edge where `fill_req_valid` and `fill_rsp_valid` are both 1, and byte k of a beat belongs to byte address base+k. After the fourth beat the requested halfword is returned and all four sub-blocks are valid. With no fill stalls the response comes six edges after acceptance.
- R5: A read whose tag matches but whose addressed sub-block is invalid is handled as a miss. It fetches the full line, which replaces bytes written earlier in the other sub-blocks.
- R6: A write hit (tag match and valid sub-block) changes only the bytes enabled by `cpu_req_be`. Bit 0 of the mask selects data bits 7:0 at the even byte, and bit 1 selects bits 15:8 at the odd byte. The valid bits are not changed.
- R7: A write miss makes no fill request. It replaces the tag, stores the enabled bytes, sets the written sub-block valid and clears the valid bits of the other three sub-blocks.
- R8: Every write, hit or miss, is presented on the write-through channel with the halfword-aligned address (bit 0 zero), the data and the mask. The channel holds these steady while `wt_ready` is 0. The processor response follows the edge where the write is accepted, so with no stalls it arrives three edges after acceptance.
- R9: `cpu_req_ready` is 1 only when the controller is idle. It drops the cycle after a request is accepted and is 1 again in the cycle the response is valid.
- R10: `cpu_resp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller idle, request accepted this edge |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 16 | Write halfword |
| cpu_req_be | input | 2 | Byte mask for writes |
| cpu_resp_valid | output | 1 | Response pulse |
| cpu_resp_rdata | output | 16 | Read halfword (0 for writes) |
| fill_req_valid | output | 1 | Fill beat requested |
| fill_req_addr | output | 32 | Address of the requested 8-byte beat |
| fill_rsp_valid | input | 1 | Beat data present this cycle |
| fill_rsp_data | input | 64 | Beat data |
| wt_valid | output | 1 | Write-through request |
| wt_ready | input | 1 | Memory accepts the write-through |
| wt_addr | output | 32 | Write-through address |
| wt_data | output | 16 | Write-through data |
| wt_be | output | 2 | Write-through byte mask |

## Verification
The assertions check on every cycle that the fill always starts at sub-block 0 and steps up by one per beat. They also check that a completed fill leaves all four valid bits set, that a write miss leaves exactly one valid bit with the new tag, and that a write hit leaves the valid bits alone. Further cycle checks cover read hits, which respond without touching memory; write-through requests, which stay stable under back-pressure; the single-cycle response pulse; and the busy ready signal. Only the bench's scenarios can show the returned data and which bytes a partial write changed. They also show how a write-installed sub-block behaves once a later read refills the line, the latencies under fill and write stalls, and that a second reset forgets lines that were resident.

// File: rtl/sbk_pkg.sv
package sbk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2,
    ST_WT   = 2'd3
  } sbk_state_e;
endpackage

// File: rtl/sbk_data_ram.sv
// Line data storage: one word per sub-block, byte-lane write enables,
// registered read port, written for block RAM inference.
module sbk_data_ram #(
  parameter int DEPTH = 128,
  parameter int BYTES = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = BYTES * 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [BYTES-1:0] wr_be,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wr_be[b]) mem[wr_addr][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/sbk_tag_store.sv
// Tag per line (no reset) plus one valid bit per sub-block (reset to zero).
module sbk_tag_store #(
  parameter int LINES = 32,
  parameter int TAG_W = 22,
  parameter int SUBS  = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic [SUBS-1:0]  rd_valid,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic [SUBS-1:0]  upd_valid
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [SUBS-1:0]  vld_q [LINES];
  logic             any_valid;

  always_ff @(posedge clk) begin
    if (upd_en) tag_q[upd_idx] <= upd_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) vld_q[i] <= '0;
    end else if (upd_en) begin
      vld_q[upd_idx] <= upd_valid;
    end
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = vld_q[rd_idx];

  always_comb begin
    any_valid = 1'b0;
    for (int i = 0; i < LINES; i++) any_valid = any_valid | (|vld_q[i]);
  end

  // R1: the cycle after reset no sub-block of any line is valid
  assert_reset_clears_valid_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !any_valid);
endmodule

// File: rtl/sbk_cache.sv
module sbk_cache #(
  parameter int ADDR_W      = 32,
  parameter int CPU_W       = 16,
  parameter int LINE_COUNT  = 32,
  parameter int BLOCK_BYTES = 32,
  parameter int SUB_BYTES   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_req_valid,
  output logic                    cpu_req_ready,
  input  logic                    cpu_req_write,
  input  logic [ADDR_W-1:0]       cpu_req_addr,
  input  logic [CPU_W-1:0]        cpu_req_wdata,
  input  logic [CPU_W/8-1:0]      cpu_req_be,
  output logic                    cpu_resp_valid,
  output logic [CPU_W-1:0]        cpu_resp_rdata,
  output logic                    fill_req_valid,
  output logic [ADDR_W-1:0]       fill_req_addr,
  input  logic                    fill_rsp_valid,
  input  logic [SUB_BYTES*8-1:0]  fill_rsp_data,
  output logic                    wt_valid,
  input  logic                    wt_ready,
  output logic [ADDR_W-1:0]       wt_addr,
  output logic [CPU_W-1:0]        wt_data,
  output logic [CPU_W/8-1:0]      wt_be
);
  import sbk_pkg::*;

  localparam int CPU_BYTES = CPU_W / 8;
  localparam int BEAT_W    = SUB_BYTES * 8;
  localparam int SUBS      = BLOCK_BYTES / SUB_BYTES;
  localparam int LANES     = SUB_BYTES / CPU_BYTES;
  localparam int IDX_W     = $clog2(LINE_COUNT);
  localparam int OFF_W     = $clog2(BLOCK_BYTES);
  localparam int SB_W      = $clog2(SUBS);
  localparam int BOFF_W    = $clog2(SUB_BYTES);
  localparam int LANE_W    = $clog2(LANES);
  localparam int CB_W      = $clog2(CPU_BYTES);
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W;
  localparam int RAM_DEPTH = LINE_COUNT * SUBS;
  localparam int RAM_AW    = IDX_W + SB_W;
  localparam logic [SB_W-1:0] LAST_SB = SB_W'(SUBS - 1);

  // request registers
  sbk_state_e         st;
  logic               rq_we;
  logic [TAG_W-1:0]   rq_tag;
  logic [IDX_W-1:0]   rq_idx;
  logic [SB_W-1:0]    rq_sb;
  logic [LANE_W-1:0]  rq_lane;
  logic [CPU_W-1:0]   rq_wdata;
  logic [CPU_BYTES-1:0] rq_be;
  logic [SB_W-1:0]    fill_cnt;
  logic [BEAT_W-1:0]  fill_hold;
  logic               resp_v_q;
  logic [CPU_W-1:0]   resp_d_q;
  logic               fill_v_q;
  logic               wt_v_q;

  // lookup and storage nets
  logic [TAG_W-1:0]   lk_tag;
  logic [SUBS-1:0]    lk_valid;
  logic               hit;
  logic               beat;
  logic [BEAT_W-1:0]  ram_rdata;
  logic               ram_we;
  logic [SUB_BYTES-1:0] ram_wbe;
  logic [RAM_AW-1:0]  ram_waddr;
  logic [BEAT_W-1:0]  ram_wdata;
  logic               ram_re;
  logic [RAM_AW-1:0]  ram_raddr;
  logic               upd_en;
  logic [SUBS-1:0]    upd_valid;
  logic [BEAT_W-1:0]  fill_sel;
  logic [BEAT_W-1:0]  wr_spread;
  logic [SUB_BYTES-1:0] lane_be;
  logic               unused_addr_lsb;

  assign unused_addr_lsb = ^cpu_req_addr[CB_W-1:0];

  sbk_tag_store #(
    .LINES (LINE_COUNT),
    .TAG_W (TAG_W),
    .SUBS  (SUBS)
  ) u_tags (
    .clk       (clk),
    .rst       (rst),
    .rd_idx    (rq_idx),
    .rd_tag    (lk_tag),
    .rd_valid  (lk_valid),
    .upd_en    (upd_en),
    .upd_idx   (rq_idx),
    .upd_tag   (rq_tag),
    .upd_valid (upd_valid)
  );

  sbk_data_ram #(
    .DEPTH (RAM_DEPTH),
    .BYTES (SUB_BYTES)
  ) u_data (
    .clk     (clk),
    .wr_en   (ram_we),
    .wr_be   (ram_wbe),
    .wr_addr (ram_waddr),
    .wr_data (ram_wdata),
    .rd_en   (ram_re),
    .rd_addr (ram_raddr),
    .rd_data (ram_rdata)
  );

  // halfword replicated across every lane of the beat
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_spread
      assign wr_spread[l*CPU_W +: CPU_W] = rq_wdata;
    end
  endgenerate

  assign hit     = (lk_tag == rq_tag) && lk_valid[rq_sb];
  assign beat    = (st == ST_FILL) && fill_rsp_valid;
  assign lane_be = SUB_BYTES'(rq_be) << (rq_lane * CPU_BYTES);

  assign ram_re    = (st == ST_IDLE) && cpu_req_valid;
  assign ram_raddr = {cpu_req_addr[OFF_W +: IDX_W], cpu_req_addr[BOFF_W +: SB_W]};
  assign ram_we    = ((st == ST_LOOK) && rq_we) || beat;
  assign ram_waddr = {rq_idx, (st == ST_FILL) ? fill_cnt : rq_sb};
  assign ram_wdata = (st == ST_FILL) ? fill_rsp_data : wr_spread;
  assign ram_wbe   = (st == ST_FILL) ? {SUB_BYTES{1'b1}} : lane_be;

  // tag/valid update: write miss installs one sub-block, last fill beat all
  assign upd_en    = ((st == ST_LOOK) && rq_we && !hit) || (beat && (fill_cnt == LAST_SB));
  assign upd_valid = (st == ST_FILL) ? {SUBS{1'b1}} : (SUBS'(1) << rq_sb);

  assign fill_sel = (fill_cnt == rq_sb) ? fill_rsp_data : fill_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      rq_we     <= 1'b0;
      rq_tag    <= '0;
      rq_idx    <= '0;
      rq_sb     <= '0;
      rq_lane   <= '0;
      rq_wdata  <= '0;
      rq_be     <= '0;
      fill_cnt  <= '0;
      fill_hold <= '0;
      resp_v_q  <= 1'b0;
      resp_d_q  <= '0;
      fill_v_q  <= 1'b0;
      wt_v_q    <= 1'b0;
    end else begin
      resp_v_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cpu_req_valid) begin
            rq_we    <= cpu_req_write;
            rq_tag   <= cpu_req_addr[ADDR_W-1 -: TAG_W];
            rq_idx   <= cpu_req_addr[OFF_W +: IDX_W];
            rq_sb    <= cpu_req_addr[BOFF_W +: SB_W];
            rq_lane  <= cpu_req_addr[CB_W +: LANE_W];
            rq_wdata <= cpu_req_wdata;
            rq_be    <= cpu_req_be;
            st       <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (rq_we) begin
            wt_v_q <= 1'b1;
            st     <= ST_WT;
          end else if (hit) begin
            resp_v_q <= 1'b1;
            resp_d_q <= ram_rdata[rq_lane*CPU_W +: CPU_W];
            st       <= ST_IDLE;
          end else begin
            fill_v_q <= 1'b1;
            fill_cnt <= '0;
            st       <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (fill_rsp_valid) begin
            if (fill_cnt == rq_sb) fill_hold <= fill_rsp_data;
            if (fill_cnt == LAST_SB) begin
              fill_v_q <= 1'b0;
              resp_v_q <= 1'b1;
              resp_d_q <= fill_sel[rq_lane*CPU_W +: CPU_W];
              st       <= ST_IDLE;
            end else begin
              fill_cnt <= fill_cnt + 1'b1;
            end
          end
        end
        ST_WT: begin
          if (wt_ready) begin
            wt_v_q   <= 1'b0;
            resp_v_q <= 1'b1;
            resp_d_q <= '0;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cpu_req_ready  = (st == ST_IDLE);
  assign cpu_resp_valid = resp_v_q;
  assign cpu_resp_rdata = resp_d_q;
  assign fill_req_valid = fill_v_q;
  assign fill_req_addr  = {rq_tag, rq_idx, fill_cnt, {BOFF_W{1'b0}}};
  assign wt_valid       = wt_v_q;
  assign wt_addr        = {rq_tag, rq_idx, rq_sb, rq_lane, {CB_W{1'b0}}};
  assign wt_data        = rq_wdata;
  assign wt_be          = rq_be;

  // R3: a read hit answers next cycle with no memory traffic
  assert_hit_no_traffic_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOOK && !rq_we && hit) |=> (cpu_resp_valid && !fill_req_valid && !wt_valid));

  // R4: fill starts at sub-block 0
  assert_fill_starts_zero_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(fill_req_valid) |-> (fill_req_addr[BOFF_W +: SB_W] == '0));

  // R4: fill advances one sub-block per accepted beat
  assert_fill_in_order_R4: assert property (@(posedge clk) disable iff (rst)
    (fill_req_valid && fill_rsp_valid && fill_req_addr[BOFF_W +: SB_W] != LAST_SB)
    |=> (fill_req_valid &&
         fill_req_addr[BOFF_W +: SB_W] == $past(fill_req_addr[BOFF_W +: SB_W]) + 1'b1));

  // R4: completed fill leaves all sub-blocks valid
  assert_fill_all_valid_R4: assert property (@(posedge clk) disable iff (rst)
    (fill_req_valid && fill_rsp_valid && fill_req_addr[BOFF_W +: SB_W] == LAST_SB)
    |=> (&lk_valid));

  // R7: write miss leaves exactly one valid sub-block under the new tag
  assert_write_miss_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOOK && rq_we && !hit) |=> ($onehot(lk_valid) && lk_tag == $past(rq_tag)));

  // R6: write hit keeps the valid bits
  assert_write_hit_keeps_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOOK && rq_we && hit) |=> $stable(lk_valid));

  // R7: writes never fetch
  assert_write_no_fill_R7: assert property (@(posedge clk) disable iff (rst)
    wt_valid |-> !fill_req_valid);

  // R8: write-through request held stable under back-pressure
  assert_wt_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (wt_valid && !wt_ready) |=> (wt_valid && $stable(wt_addr) && $stable(wt_data) && $stable(wt_be)));

  // R9: busy after acceptance
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

  // R10: response is a single-cycle pulse
  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    cpu_resp_valid |=> !cpu_resp_valid);
endmodule

// File: tb/sbk_cache_bench.sv
module sbk_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  typedef struct packed {
    logic        we;
    logic [31:0] a;
    logic [15:0] d;
    logic [1:0]  be;
  } vec_t;

  // stimulus table; expected results come from the bench model
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'h0000_1240, 16'h0000, 2'b00},  // read miss, cold line
    '{1'b0, 32'h0000_125A, 16'h0000, 2'b00},  // read hit sb3
    '{1'b1, 32'h0000_124C, 16'hBEEF, 2'b01},  // write hit, low byte only
    '{1'b0, 32'h0000_124C, 16'h0000, 2'b00},  // read back partial write
    '{1'b1, 32'h0000_5672, 16'h1234, 2'b11},  // write miss on empty line
    '{1'b0, 32'h0000_5672, 16'h0000, 2'b00},  // read installed sub-block
    '{1'b0, 32'h0000_5662, 16'h0000, 2'b00},  // tag match, invalid sb0
    '{1'b0, 32'h0000_5672, 16'h0000, 2'b00},  // after refill
    '{1'b1, 32'h0000_1648, 16'hCAFE, 2'b11},  // write miss, conflicting tag
    '{1'b0, 32'h0000_1648, 16'h0000, 2'b00},  // hit on installed sb1
    '{1'b0, 32'h0000_1650, 16'h0000, 2'b00},  // tag match, sb2 invalid
    '{1'b0, 32'h0000_1240, 16'h0000, 2'b00},  // old tag gone
    '{1'b0, 32'h0000_03FE, 16'h0000, 2'b00},  // last line, last halfword
    '{1'b0, 32'h0000_03E0, 16'h0000, 2'b00},  // hit same line
    '{1'b1, 32'h0000_124E, 16'h7788, 2'b10},  // write hit, high byte only
    '{1'b0, 32'h0000_124E, 16'h0000, 2'b00}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_req_valid, cpu_req_write;
  logic [31:0] cpu_req_addr;
  logic [15:0] cpu_req_wdata;
  logic [1:0]  cpu_req_be;
  logic        cpu_req_ready, cpu_resp_valid;
  logic [15:0] cpu_resp_rdata;
  logic        fill_req_valid;
  logic [31:0] fill_req_addr;
  logic        fill_rsp_valid = 1'b1;
  logic [63:0] fill_rsp_data;
  logic        wt_valid;
  logic        wt_ready = 1'b1;
  logic [31:0] wt_addr;
  logic [15:0] wt_data;
  logic [1:0]  wt_be;

  int n_checks = 0;
  int n_err    = 0;
  int fill_stall = 0;
  int wt_stall   = 0;
  int beat_n = 0;
  int wt_n   = 0;
  logic [31:0] beat_addr [4];
  logic [31:0] wt_seen_a;
  logic [15:0] wt_seen_d;
  logic [1:0]  wt_seen_be;
  logic [15:0] last_rd, last_exp;

  // bench model of the cache contents
  logic [21:0] m_tag [32];
  logic [3:0]  m_vld [32];
  logic [7:0]  m_byte [1024];

  always #(CLK_PERIOD/2) clk = ~clk;

  sbk_cache u_sbk_cache (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_req_be(cpu_req_be),
    .cpu_resp_valid(cpu_resp_valid), .cpu_resp_rdata(cpu_resp_rdata),
    .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
    .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data),
    .wt_valid(wt_valid), .wt_ready(wt_ready), .wt_addr(wt_addr),
    .wt_data(wt_data), .wt_be(wt_be)
  );

  function automatic logic [63:0] mem_beat(input logic [31:0] a);
    return {a ^ 32'h5A5A_0F0F, ~a ^ 32'h1234_0000};
  endfunction

  assign fill_rsp_data = mem_beat(fill_req_addr);

  // memory-side responders and monitors, away from the active edge
  always @(negedge clk) begin
    if (fill_req_valid && fill_stall > 0) begin
      fill_rsp_valid = 1'b0;
      fill_stall--;
    end else begin
      fill_rsp_valid = 1'b1;
    end
    if (fill_req_valid && fill_rsp_valid) begin
      if (beat_n < 4) beat_addr[beat_n] = fill_req_addr;
      beat_n++;
    end
    if (wt_valid && wt_stall > 0) begin
      wt_ready = 1'b0;
      wt_stall--;
    end else begin
      wt_ready = 1'b1;
    end
    if (wt_valid && wt_ready) begin
      wt_n++;
      wt_seen_a  = wt_addr;
      wt_seen_d  = wt_data;
      wt_seen_be = wt_be;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_vec(input logic we, input logic [31:0] a,
                        input logic [15:0] d, input logic [1:0] be);
    logic [4:0]  idx;
    logic [21:0] tag;
    logic [1:0]  sb;
    int          base, off, lat, exp_lat, fst, wst;
    logic        hit, tmatch, busy, rdy_at_resp, pulse_after;
    string       req;
    idx  = a[9:5];
    tag  = a[31:10];
    sb   = a[4:3];
    base = int'(idx) * 32;
    off  = int'({a[4:1], 1'b0});
    tmatch = (m_tag[idx] == tag) && (m_vld[idx] != 4'b0);
    hit    = (m_tag[idx] == tag) && m_vld[idx][sb];
    fst = fill_stall;
    wst = wt_stall;
    if (we) req = hit ? "R6" : "R7";
    else    req = hit ? "R3" : (tmatch ? "R5" : "R4");
    // update model
    if (!we) begin
      if (!hit) begin
        for (int s = 0; s < 4; s++) begin
          logic [63:0] bt;
          bt = mem_beat({a[31:5], 2'(s), 3'b000});
          for (int k = 0; k < 8; k++) m_byte[base + s*8 + k] = bt[k*8 +: 8];
        end
        m_tag[idx] = tag;
        m_vld[idx] = 4'hF;
      end
      last_exp = {m_byte[base + off + 1], m_byte[base + off]};
      exp_lat  = hit ? 2 : 6 + fst;
    end else begin
      if (!hit) begin
        m_tag[idx] = tag;
        m_vld[idx] = 4'b0001 << sb;
      end
      if (be[0]) m_byte[base + off]     = d[7:0];
      if (be[1]) m_byte[base + off + 1] = d[15:8];
      last_exp = 16'h0;
      exp_lat  = 3 + wst;
    end
    // drive request
    beat_n = 0;
    wt_n   = 0;
    @(negedge clk);
    chk("R9", "ready before request", 64'(cpu_req_ready), 64'd1);
    cpu_req_valid = 1'b1;
    cpu_req_write = we;
    cpu_req_addr  = a;
    cpu_req_wdata = d;
    cpu_req_be    = be;
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    busy = cpu_req_ready;
    lat  = 1;
    while (!cpu_resp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    last_rd     = cpu_resp_rdata;
    rdy_at_resp = cpu_req_ready;
    @(negedge clk);
    pulse_after = cpu_resp_valid;
    // checks
    chk("R9", "busy after accept", 64'(busy), 64'd0);
    chk("R9", "ready with response", 64'(rdy_at_resp), 64'd1);
    chk("R10", "response pulse width", 64'(pulse_after), 64'd0);
    chk(req, "latency", 64'(lat), 64'(exp_lat));
    if (!we) begin
      chk(req, "read data", 64'(last_rd), 64'(last_exp));
      chk(req, "fill beats", 64'(beat_n), hit ? 64'd0 : 64'd4);
      if (!hit) begin
        for (int s = 0; s < 4; s++)
          chk("R4", "fill beat address order", 64'(beat_addr[s]),
              64'({a[31:5], 2'(s), 3'b000}));
      end
    end else begin
      chk("R7", "no fill on write", 64'(beat_n), 64'd0);
      chk("R8", "write-through count", 64'(wt_n), 64'd1);
      chk("R8", "write-through address", 64'(wt_seen_a), 64'({a[31:1], 1'b0}));
      chk("R8", "write-through data", 64'(wt_seen_d), 64'(d));
      chk("R8", "write-through mask", 64'(wt_seen_be), 64'(be));
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_tag[i] = '0;
      m_vld[i] = '0;
    end
    for (int i = 0; i < 1024; i++) m_byte[i] = '0;
    rst = 1'b1;
    cpu_req_valid = 1'b0;
    cpu_req_write = 1'b0;
    cpu_req_addr  = '0;
    cpu_req_wdata = '0;
    cpu_req_be    = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "ready after reset", 64'(cpu_req_ready), 64'd1);
    chk("R1", "resp idle after reset", 64'(cpu_resp_valid), 64'd0);
    chk("R1", "fill idle after reset", 64'(fill_req_valid), 64'd0);
    chk("R1", "write-through idle after reset", 64'(wt_valid), 64'd0);

    // table walk
    for (int v = 0; v < NVEC; v++) do_vec(VECS[v].we, VECS[v].a, VECS[v].d, VECS[v].be);

    // R2: odd address reads the even halfword (line 18 resident)
    do_vec(1'b0, 32'h0000_1240, 16'h0, 2'b00);
    begin
      logic [15:0] even_rd;
      even_rd = last_rd;
      do_vec(1'b0, 32'h0000_1241, 16'h0, 2'b00);
      chk("R2", "odd address ignores bit 0", 64'(last_rd), 64'(even_rd));
    end

    // R4: read miss with fill stalls
    fill_stall = 3;
    do_vec(1'b0, 32'h0000_7016, 16'h0, 2'b00);
    fill_stall = 0;

    // R8: write-through back-pressure
    wt_stall = 2;
    do_vec(1'b1, 32'h0000_7016, 16'hA1B2, 2'b11);
    wt_stall = 0;
    do_vec(1'b0, 32'h0000_7016, 16'h0, 2'b00);
    chk("R6", "write hit after stall read back", 64'(last_rd), 64'h0000_0000_0000_A1B2);

    // R1: a second reset forgets resident lines
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) m_vld[i] = '0;
    do_vec(1'b0, 32'h0000_1240, 16'h0, 2'b00);
    chk("R1", "read after reset misses", 64'(beat_n), 64'd4);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule